// File: doc/BRIEF.md
# Dual-Bank Memory Bus Front-End

This block decodes the host side of a memory made of two identical 16-bit banks sharing one bus. It samples active-low strobes (a master chip enable, an output enable and a write enable), a pair of active-low bank selects, a byte-mode select, an address and the incoming data word on a fast system clock. From these samples it decides which bank is addressed and whether the bus cycle is a read, a write or idle.

For reads it raises per-lane output enables and steers the selected bank's word, or one byte of it, onto the outgoing data lanes. For writes it holds the last address and data seen while write enable was low, and emits a one-cycle write pulse to the addressed bank when write enable returns high. An illegal select pattern (both bank selects low at once) enables no bank, raises a live flag and sets a sticky flag that only reset clears.

Every decoded output reflects the inputs sampled at the previous clock edge.

Top module: `dual_bank_front`

## Requirements
- R1: A bank is active only when `ce_n` is low and exactly one of `bsel_n[0]`, `bsel_n[1]` is low; `bsel_n[0]` low selects bank 0 (`bank_act` = 2'b01), `bsel_n[1]` low selects bank 1 (`bank_act` = 2'b10); otherwise `bank_act` is 0.
- R2: With `ce_n` low and both bank selects low, `bank_act` is 0 and `sel_err` is 1; one cycle later `err_sticky` is 1 and it stays 1 until reset, even after the selects become legal.
- R3: `dq_oe_lo` is 1 only when a bank is active and `oe_n` is low; both lane enables are 0 when the chip is deselected or `oe_n` is high.
- R4: Output enable has priority over write enable: with a bank active, `oe_n` low and `we_n` low, the cycle is a read (`cyc_read` = 1, `cyc_write` = 0) and no write pulse follows when `we_n` rises.
- R5: After a write cycle (bank active, `oe_n` high, `we_n` low), the sample in which `we_n` is high gives exactly one cycle of `wr_pulse` with the bit of the written bank set, and `wr_data`, `wr_blk`, `wr_word` hold the values present while `we_n` was low.
- R6: In byte mode (`byte_mode` = 1) a read drives only the low lane (`dq_oe_hi` = 0), carrying the upper byte of `rd_word` when `addr[0]` = 1 and the lower byte when `addr[0]` = 0; a byte write gives `wr_byte_hi` = `addr[0]` and `wr_data` = {8'h00, `dq_in[7:0]`}.
- R7: In word mode (`byte_mode` = 0) `addr[0]` is ignored: reads drive both lanes with `rd_word` unchanged and writes give `wr_byte_hi` = 0 and the full `dq_in` word.
- R8: During a status read (`status_rd` = 1) the upper lane is not driven (`dq_oe_hi` = 0) and the low lane carries `rd_word[7:0]`.
- R9: On a write, `wr_blk` equals `addr[20:16]` (one of 32 blocks) and `wr_word` equals `addr[15:1]` (word within a 64-Kbyte block).
- R10: After reset all outputs that signal activity (`bank_act`, `cyc_read`, `cyc_write`, `dq_oe_lo`, `dq_oe_hi`, `wr_pulse`, `sel_err`, `err_sticky`) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Master chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; capture on its rise |
| bsel_n | input | 2 | Bank selects, active low; bit 0 for bank 0, bit 1 for bank 1 |
| byte_mode | input | 1 | 1 = 8-bit bus cycles, 0 = 16-bit |
| status_rd | input | 1 | 1 = current read returns status |
| addr | input | 21 | Byte address |
| dq_in | input | 16 | Write data from the host |
| rd_word | input | 16 | Read word from the active bank |
| dq_out | output | 16 | Steered read data |
| dq_oe_lo | output | 1 | Drive enable for lane bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for lane bits 15:8 |
| bank_act | output | 2 | One-hot active bank |
| cyc_read | output | 1 | Current sample is a read cycle |
| cyc_write | output | 1 | Current sample is a write cycle |
| wr_pulse | output | 2 | One-cycle write strobe per bank |
| wr_blk | output | 5 | Captured block index |
| wr_word | output | 15 | Captured word index |
| wr_byte_hi | output | 1 | Captured byte-lane select for byte writes |
| wr_data | output | 16 | Captured write data |
| sel_err | output | 1 | Both bank selects low with chip enabled |
| err_sticky | output | 1 | Latched illegal-select flag |

## Verification
The bench builds the block with its default parameters: a 21-bit address, 16-bit data and block field starting at bit 16. This puts the highest block index 31 and the highest word index within a block within reach of the write tests. It also makes the byte-lane steering of both halves of the 16-bit word observable in reads and writes.

// File: rtl/dual_bank_front.sv
module dual_bank_front #(
  parameter int AW      = 21,
  parameter int DW      = 16,
  parameter int BLK_LSB = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic [1:0]            bsel_n,
  input  logic                  byte_mode,
  input  logic                  status_rd,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         dq_in,
  input  logic [DW-1:0]         rd_word,
  output logic [DW-1:0]         dq_out,
  output logic                  dq_oe_lo,
  output logic                  dq_oe_hi,
  output logic [1:0]            bank_act,
  output logic                  cyc_read,
  output logic                  cyc_write,
  output logic [1:0]            wr_pulse,
  output logic [AW-BLK_LSB-1:0] wr_blk,
  output logic [BLK_LSB-2:0]    wr_word,
  output logic                  wr_byte_hi,
  output logic [DW-1:0]         wr_data,
  output logic                  sel_err,
  output logic                  err_sticky
);
  localparam int HW = DW / 2;

  logic          s_ce, s_oe, s_we, s_byte, s_stat;
  logic [1:0]    s_bs;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_ce   <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_bs   <= 2'b11;
      s_byte <= 1'b0;
      s_stat <= 1'b0;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce   <= ce_n;
      s_oe   <= oe_n;
      s_we   <= we_n;
      s_bs   <= bsel_n;
      s_byte <= byte_mode;
      s_stat <= status_rd;
      s_addr <= addr;
      s_din  <= dq_in;
    end

  wire active = !s_ce && (s_bs[0] ^ s_bs[1]);
  assign bank_act  = active ? ~s_bs : 2'b00;
  assign sel_err   = !s_ce && (s_bs == 2'b00);
  assign cyc_read  = active && !s_oe;
  assign cyc_write = active && s_oe && !s_we;

  assign dq_oe_lo = cyc_read;
  assign dq_oe_hi = cyc_read && !s_byte && !s_stat;
  assign dq_out[DW-1:HW] = rd_word[DW-1:HW];
  assign dq_out[HW-1:0]  = (s_byte && !s_stat && s_addr[0]) ? rd_word[DW-1:HW]
                                                            : rd_word[HW-1:0];

  logic          wr_prev, c_byte;
  logic [1:0]    c_bank;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_prev    <= 1'b0;
      c_byte     <= 1'b0;
      c_bank     <= 2'b00;
      c_addr     <= '0;
      c_data     <= '0;
      err_sticky <= 1'b0;
    end else begin
      wr_prev    <= cyc_write;
      err_sticky <= err_sticky | sel_err;
      if (cyc_write) begin
        c_bank <= bank_act;
        c_byte <= s_byte;
        c_addr <= s_addr;
        c_data <= s_din;
      end
    end

  assign wr_pulse   = (wr_prev && s_we) ? c_bank : 2'b00;
  assign wr_blk     = c_addr[AW-1:BLK_LSB];
  assign wr_word    = c_addr[BLK_LSB-1:1];
  assign wr_byte_hi = c_byte && c_addr[0];
  assign wr_data    = c_byte ? {{(DW-HW){1'b0}}, c_data[HW-1:0]} : c_data;
endmodule

module dual_bank_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_act,
  input logic       sel_err,
  input logic       err_sticky,
  input logic       cyc_read,
  input logic       cyc_write,
  input logic       dq_oe_lo,
  input logic       dq_oe_hi,
  input logic [1:0] wr_pulse
);
  assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_act));
  assert_illegal_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> bank_act == 2'b00);
  assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> err_sticky);
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  assert_float_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_act == 2'b00 |-> !dq_oe_lo && !dq_oe_hi);
  assert_read_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_read |-> !cyc_write);
  assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse != 2'b00 |=> wr_pulse == 2'b00);
  assert_pulse_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse != 2'b00 |-> $past(cyc_write));
  assert_pulse_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_pulse));
  assert_upper_needs_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_hi |-> dq_oe_lo);
endmodule

bind dual_bank_front dual_bank_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_act(bank_act), .sel_err(sel_err),
  .err_sticky(err_sticky), .cyc_read(cyc_read), .cyc_write(cyc_write),
  .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .wr_pulse(wr_pulse)
);

// File: tb/dual_bank_front_test.sv
module dual_bank_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1, oe_n = 1, we_n = 1, byte_mode = 0, status_rd = 0;
  logic [1:0]  bsel_n = 2'b11;
  logic [20:0] addr = '0;
  logic [15:0] dq_in = '0, rd_word = '0;
  logic [15:0] dq_out, wr_data;
  logic dq_oe_lo, dq_oe_hi, cyc_read, cyc_write, wr_byte_hi, sel_err, err_sticky;
  logic [1:0]  bank_act, wr_pulse;
  logic [4:0]  wr_blk;
  logic [14:0] wr_word;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_bank_front uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .bsel_n(bsel_n), .byte_mode(byte_mode), .status_rd(status_rd),
    .addr(addr), .dq_in(dq_in), .rd_word(rd_word), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .bank_act(bank_act),
    .cyc_read(cyc_read), .cyc_write(cyc_write), .wr_pulse(wr_pulse),
    .wr_blk(wr_blk), .wr_word(wr_word), .wr_byte_hi(wr_byte_hi),
    .wr_data(wr_data), .sel_err(sel_err), .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; bsel_n = 2'b11; status_rd = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 bank_act", bank_act, 0);
    chk("R10 oe", {dq_oe_lo, dq_oe_hi, cyc_read, cyc_write}, 0);
    chk("R10 flags", {wr_pulse, sel_err, err_sticky}, 0);
  endtask

  task automatic t_select();
    ce_n = 0; bsel_n = 2'b10; @(negedge clk);
    chk("R1 bank0", bank_act, 2'b01);
    bsel_n = 2'b01; @(negedge clk);
    chk("R1 bank1", bank_act, 2'b10);
    ce_n = 1; @(negedge clk);
    chk("R1 ce high", bank_act, 0);
    ce_n = 0; bsel_n = 2'b11; @(negedge clk);
    chk("R1 none selected", bank_act, 0);
    idle();
  endtask

  task automatic t_read_word();
    byte_mode = 0; rd_word = 16'hA55A; addr = 21'h1;
    ce_n = 0; bsel_n = 2'b10; oe_n = 0; @(negedge clk);
    chk("R3 oe lo", dq_oe_lo, 1);
    chk("R7 oe hi", dq_oe_hi, 1);
    chk("R7 data addr0 ignored", dq_out, 16'hA55A);
    oe_n = 1; @(negedge clk);
    chk("R3 oe high floats", {dq_oe_lo, dq_oe_hi}, 0);
    oe_n = 0; ce_n = 1; @(negedge clk);
    chk("R3 deselect floats", {dq_oe_lo, dq_oe_hi}, 0);
    idle();
  endtask

  task automatic t_read_byte();
    byte_mode = 1; rd_word = 16'h12C4; addr = 21'h0;
    ce_n = 0; bsel_n = 2'b01; oe_n = 0; @(negedge clk);
    chk("R6 low byte", dq_out[7:0], 8'hC4);
    chk("R6 upper lane off", {dq_oe_lo, dq_oe_hi}, 2'b10);
    addr = 21'h1; @(negedge clk);
    chk("R6 high byte", dq_out[7:0], 8'h12);
    idle();
    byte_mode = 0;
  endtask

  task automatic t_status();
    rd_word = 16'hBE80; addr = 21'h1; status_rd = 1;
    ce_n = 0; bsel_n = 2'b10; oe_n = 0; @(negedge clk);
    chk("R8 upper off", {dq_oe_lo, dq_oe_hi}, 2'b10);
    chk("R8 low lane", dq_out[7:0], 8'h80);
    idle();
  endtask

  task automatic do_write(input logic [1:0] bs, input logic bm, input logic [20:0] a,
                          input logic [15:0] d);
    byte_mode = bm; addr = a; dq_in = d;
    ce_n = 0; bsel_n = bs; oe_n = 1; we_n = 0; @(negedge clk);
    chk("R5 write cycle", cyc_write, 1);
    @(negedge clk);
    chk("R5 no early pulse", wr_pulse, 0);
    addr = ~a; dq_in = ~d; we_n = 1; @(negedge clk);
  endtask

  task automatic t_write_word();
    do_write(2'b01, 0, {5'd31, 15'h7FFF, 1'b1}, 16'hC3A5);
    chk("R5 pulse bank1", wr_pulse, 2'b10);
    chk("R5 data", wr_data, 16'hC3A5);
    chk("R9 block", wr_blk, 31);
    chk("R9 word", wr_word, 15'h7FFF);
    chk("R7 byte_hi ignored", wr_byte_hi, 0);
    @(negedge clk);
    chk("R5 pulse ends", wr_pulse, 0);
    idle();
    do_write(2'b10, 0, {5'd3, 15'h0012, 1'b0}, 16'h0F0F);
    chk("R5 pulse bank0", wr_pulse, 2'b01);
    chk("R9 block 3", wr_blk, 3);
    chk("R9 word 0x12", wr_word, 15'h0012);
    idle();
  endtask

  task automatic t_write_byte();
    do_write(2'b10, 1, 21'h00005, 16'h77E1);
    chk("R6 byte_hi", wr_byte_hi, 1);
    chk("R6 byte data", wr_data, 16'h00E1);
    idle();
    do_write(2'b10, 1, 21'h00004, 16'h7734);
    chk("R6 byte_lo", wr_byte_hi, 0);
    idle();
    byte_mode = 0;
  endtask

  task automatic t_priority();
    ce_n = 0; bsel_n = 2'b10; oe_n = 0; we_n = 0; @(negedge clk);
    chk("R4 read wins", {cyc_read, cyc_write}, 2'b10);
    we_n = 1; @(negedge clk);
    chk("R4 no pulse", wr_pulse, 0);
    @(negedge clk);
    chk("R4 no pulse later", wr_pulse, 0);
    idle();
  endtask

  task automatic t_illegal();
    ce_n = 0; bsel_n = 2'b00; oe_n = 0; @(negedge clk);
    chk("R2 no bank", bank_act, 0);
    chk("R2 flag", sel_err, 1);
    chk("R2 no drive", dq_oe_lo, 0);
    bsel_n = 2'b10; @(negedge clk);
    chk("R2 sticky", err_sticky, 1);
    chk("R2 flag clears", sel_err, 0);
    idle(); idle();
    chk("R2 sticky holds", err_sticky, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R2 reset clears", err_sticky, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_read_word();
    t_read_byte();
    t_status();
    t_write_word();
    t_write_byte();
    t_priority();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule